// File: doc/BRIEF.md
# Master/Slave Receive Sync Controller

This block lines up the receive sample streams of two boards that run from one shared clock. Each board keeps a 32-bit count of the samples it has delivered. One board is set to the master role and the other to the slave role, and the two are joined by a single IO line (bit 15 of the receive IO bank). When software on the master asks for a sync, the master drives a one-clock pulse onto that line. The slave watches the same line through a two-flop synchroniser. Both boards then clear their sample counters and fire a datapath reset to their phase accumulators and receive buffers, in the same clock cycle.

Samples pass through a valid/ready stream stage. The stage either forwards the incoming I/Q words unchanged or, in counting mode, replaces them with the sample counter. In counting mode the upper half of the counter goes in the I word and the lower half goes in the Q word. A transfer happens on a cycle where `out_valid` and `out_ready` are both high. Back-pressure passes straight through: `in_ready` follows `out_ready`. While the datapath reset is high, both `out_valid` and `in_ready` are forced low and no sample moves. The counter advances once for each transfer.

Top module: `rx_sync_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no register write, `io_oe`, `io_out` and `sample_count` are all zero.
- R2: A write on `cfg_wr` loads the role from `cfg_wdata`. Bit 1 selects master and bit 2 selects slave, and master takes precedence when both are set. The role holds until the next write. Bit 0 is a sync command that is never stored.
- R3: A write with bit 0 and bit 1 both set, made while `rx_enable` is high, drives `io_out[15]` high for exactly the one cycle after the write. All other `io_out` bits stay zero. A write with bit 1 clear produces no pulse. A sync write that lands while the previous pulse is still high is dropped.
- R4: `io_oe[15]` is high exactly while the role is master. No other `io_oe` bit is ever set, so a slave or idle board never drives the line.
- R5: On the master, `dp_reset` pulses for one cycle ALIGN_DLY cycles after the sync pulse (3 by default). The sample counter reads zero on the following cycle.
- R6: In the slave role, with `rx_enable` high, a rising edge on `io_in[15]` produces a one-cycle `dp_reset` three clock edges after the line rises. A line held high gives only one pulse. A master or idle board ignores the line.
- R7: While `rx_enable` is low, `dp_reset` is high, `sample_count` is zero, `out_valid` and `in_ready` are low, and sync writes produce no pulse.
- R8: `sample_count` rises by one for each stream transfer, not once per clock.
- R9: With `count_mode` high, `out_i` carries `sample_count[31:16]` and `out_q` carries `sample_count[15:0]` for the sample being transferred. The first sample after a clear carries 0, and the count carries from Q into I past 65535.
- R10: With `count_mode` low, `out_i`/`out_q` equal `in_i`/`in_q`.
- R11: While `dp_reset` is high, `out_valid` and `in_ready` are low.
- R12: A master and a slave with default parameters, joined by the shared line, raise `dp_reset` in the same cycle and hold equal counts under the same stream stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared board clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | bit0 sync command, bit1 master, bit2 slave |
| rx_enable | input | 1 | Receive streaming enable; low holds the datapath in reset |
| count_mode | input | 1 | 1: emit counter on the stream, 0: pass samples through |
| io_in | input | 16 | Receive IO bank inputs; bit 15 is the sync line |
| io_out | output | 16 | Receive IO bank outputs; bit 15 carries the sync pulse |
| io_oe | output | 16 | Output enables; only bit 15 in the master role |
| in_valid | input | 1 | Incoming sample valid |
| in_ready | output | 1 | Incoming sample accepted |
| in_i | input | 16 | Incoming I word |
| in_q | input | 16 | Incoming Q word |
| out_valid | output | 1 | Outgoing sample valid |
| out_ready | input | 1 | Downstream ready |
| out_i | output | 16 | Outgoing I word |
| out_q | output | 16 | Outgoing Q word |
| sample_count | output | 32 | Current sample counter |
| dp_reset | output | 1 | Reset to phase accumulators and receive buffers |

## Verification
The bench builds two copies with default parameters (16-bit IO bank, sync bit 15, 16-bit words, two synchroniser flops, alignment delay 3). It wires the master's driven line into the slave, so master and slave reset alignment is observed directly rather than inferred. With the default word width, the count crosses from the Q word into the I word after 65536 transfers, which is reachable within a short run. The default window is also small enough that the bench checks every cycle of the sync window. Ready patterns are swept for every period 1 to 4 and every duty count within that period, and the expected counts are computed arithmetically.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;
  localparam int CTRL_W     = 3;
  localparam int SYNC_POS   = 0;
  localparam int MASTER_POS = 1;
  localparam int SLAVE_POS  = 2;

  typedef enum logic [1:0] {
    ROLE_IDLE   = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  function automatic role_e decode_role(input logic [CTRL_W-1:0] w);
    if (w[MASTER_POS])     return ROLE_MASTER;
    else if (w[SLAVE_POS]) return ROLE_SLAVE;
    else                   return ROLE_IDLE;
  endfunction
endpackage

// File: rtl/rsc_ctrl_reg.sv
module rsc_ctrl_reg
  import rx_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              rx_enable,
  output role_e             role,
  output logic              sync_pulse
);
  logic want_sync;

  // sync bit is a command: it only counts together with the master bit
  assign want_sync = cfg_wr & cfg_wdata[SYNC_POS] & cfg_wdata[MASTER_POS]
                     & rx_enable & ~sync_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role       <= ROLE_IDLE;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= want_sync;
      if (cfg_wr) role <= decode_role(cfg_wdata);
    end
  end

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
  // R3
  pulse_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> role == ROLE_MASTER);
endmodule

// File: rtl/rsc_pin_rx.sv
module rsc_pin_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic arm,
  output logic rise_q
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sh;
  logic                   prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      prev   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sh[0] <= pin;
      for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
      prev   <= sh[TOP];
      rise_q <= sh[TOP] & ~prev & arm;
    end
  end

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);
endmodule

// File: rtl/rsc_reset_gen.sv
module rsc_reset_gen #(
  parameter int ALIGN_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_enable,
  input  logic local_pulse,
  input  logic remote_rise,
  output logic sync_strobe,
  output logic dp_reset
);
  logic local_del;

  generate
    if (ALIGN_DLY == 0) begin : g_nodly
      assign local_del = local_pulse;
    end else begin : g_dly
      logic [ALIGN_DLY-1:0] dly;
      always_ff @(posedge clk) begin
        if (!rst_n) dly <= '0;
        else begin
          dly[0] <= local_pulse;
          for (int i = 1; i < ALIGN_DLY; i++) dly[i] <= dly[i-1];
        end
      end
      assign local_del = dly[ALIGN_DLY-1];
    end
  endgenerate

  assign sync_strobe = local_del | remote_rise;
  assign dp_reset    = ~rx_enable | sync_strobe;
endmodule

// File: rtl/rsc_sample_stream.sv
module rsc_sample_stream #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                count_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_i,
  input  logic [DATA_W-1:0]   in_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_i,
  output logic [DATA_W-1:0]   out_q,
  output logic [2*DATA_W-1:0] count
);
  localparam int CNT_W = 2 * DATA_W;

  logic fire;

  assign out_valid = in_valid & ~clr;
  assign in_ready  = out_ready & ~clr;
  assign fire      = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (fire) count <= count + 1'b1;
  end

  assign out_i = count_mode ? count[CNT_W-1:DATA_W] : in_i;
  assign out_q = count_mode ? count[DATA_W-1:0]     : in_q;

  // R5
  counter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  // R8
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> count == CNT_W'($past(count) + 1'b1));
  // R8
  counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(count));
endmodule

// File: rtl/rx_sync_ctrl.sv
module rx_sync_ctrl
  import rx_sync_pkg::*;
#(
  parameter int IO_W        = 16,
  parameter int SYNC_BIT    = 15,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ALIGN_DLY   = SYNC_STAGES + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  input  logic                rx_enable,
  input  logic                count_mode,
  input  logic [IO_W-1:0]     io_in,
  output logic [IO_W-1:0]     io_out,
  output logic [IO_W-1:0]     io_oe,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_i,
  input  logic [DATA_W-1:0]   in_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_i,
  output logic [DATA_W-1:0]   out_q,
  output logic [2*DATA_W-1:0] sample_count,
  output logic                dp_reset
);
  localparam logic [IO_W-1:0] SEL = IO_W'(1) << SYNC_BIT;

  role_e role;
  logic  sync_pulse, is_master, slave_arm, pin, remote_rise, sync_strobe;

  rsc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rx_enable(rx_enable), .role(role), .sync_pulse(sync_pulse)
  );

  assign is_master = (role == ROLE_MASTER);
  assign slave_arm = (role == ROLE_SLAVE) & rx_enable;
  assign pin       = |(io_in & SEL);

  for (genvar b = 0; b < IO_W; b++) begin : g_io
    if (b == SYNC_BIT) begin : g_sync
      assign io_oe[b]  = is_master;
      assign io_out[b] = sync_pulse;
    end else begin : g_quiet
      assign io_oe[b]  = 1'b0;
      assign io_out[b] = 1'b0;
    end
  end

  rsc_pin_rx #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(pin), .arm(slave_arm), .rise_q(remote_rise)
  );

  rsc_reset_gen #(.ALIGN_DLY(ALIGN_DLY)) u_rst (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .local_pulse(sync_pulse),
    .remote_rise(remote_rise), .sync_strobe(sync_strobe), .dp_reset(dp_reset)
  );

  rsc_sample_stream #(.DATA_W(DATA_W)) u_strm (
    .clk(clk), .rst_n(rst_n), .clr(dp_reset), .count_mode(count_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .count(sample_count)
  );

  // R4
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> io_oe == '0);
  // R7
  disabled_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> (!out_valid && !in_ready && dp_reset));
  // R3
  pulse_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out != '0) |-> (io_oe == io_out));
endmodule

// File: tb/sim_rx_sync_ctrl.sv
module sim_rx_sync_ctrl;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, rx_enable, count_mode, in_valid, out_ready, tb_pin;
  logic [15:0] in_i, in_q;
  logic cfg0_wr, cfg1_wr;
  logic [2:0] cfg0_wdata, cfg1_wdata;
  logic shared_pin;
  logic [15:0] io_in_w;

  logic [15:0] out0_io, oe0_io, out1_io, oe1_io;
  logic in_ready0, out_valid0, dp0, in_ready1, out_valid1, dp1;
  logic [15:0] oi0, oq0, oi1, oq1;
  logic [31:0] cnt0, cnt1;

  int checks = 0, errors = 0;

  assign shared_pin = oe0_io[15] ? out0_io[15] : tb_pin;
  assign io_in_w    = {shared_pin, 15'b0};

  rx_sync_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg0_wr), .cfg_wdata(cfg0_wdata),
    .rx_enable(rx_enable), .count_mode(count_mode), .io_in(io_in_w),
    .io_out(out0_io), .io_oe(oe0_io), .in_valid(in_valid), .in_ready(in_ready0),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid0), .out_ready(out_ready),
    .out_i(oi0), .out_q(oq0), .sample_count(cnt0), .dp_reset(dp0));

  rx_sync_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg1_wr), .cfg_wdata(cfg1_wdata),
    .rx_enable(rx_enable), .count_mode(count_mode), .io_in(io_in_w),
    .io_out(out1_io), .io_oe(oe1_io), .in_valid(in_valid), .in_ready(in_ready1),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid1), .out_ready(out_ready),
    .out_i(oi1), .out_q(oq1), .sample_count(cnt1), .dp_reset(dp1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [2:0] d);
    @(negedge clk); cfg0_wr = 1; cfg0_wdata = d;
    @(negedge clk); cfg0_wr = 0;
  endtask

  task automatic wr1(input logic [2:0] d);
    @(negedge clk); cfg1_wr = 1; cfg1_wdata = d;
    @(negedge clk); cfg1_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] model;
    logic [31:0] exp_total;
    rst_n = 0; rx_enable = 0; count_mode = 1; in_valid = 0; out_ready = 0;
    tb_pin = 0; in_i = 0; in_q = 0; cfg0_wr = 0; cfg1_wr = 0;
    cfg0_wdata = 0; cfg1_wdata = 0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {oe0_io, oe1_io}, 0);
    check("R1 out in reset", {out0_io, out1_io}, 0);
    check("R1 count in reset", cnt0 | cnt1, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 oe after reset", {oe0_io, oe1_io}, 0);
    check("R1 count after reset", cnt0, 0);

    // R7: disabled, sync write ignored
    in_valid = 1; out_ready = 1;
    wr0(3'b011);
    check("R7 no pulse while disabled", out0_io, 16'h0000);
    check("R4 master drives oe", oe0_io, 16'h8000);
    check("R7 out_valid low", out_valid0, 0);
    check("R7 in_ready low", in_ready0, 0);
    check("R7 dp_reset high", dp0, 1);
    check("R7 count zero", cnt0, 0);
    wr1(3'b100);
    check("R4 slave no drive", oe1_io, 16'h0000);
    check("R2 master role kept", oe0_io, 16'h8000);

    // R8 / R9 sweep of ready patterns
    @(negedge clk); rx_enable = 1; out_ready = 0;
    model = 0; exp_total = 0;
    for (int p = 1; p <= 4; p++) begin
      for (int q = 0; q <= p; q++) begin
        for (int c = 0; c < 24; c++) begin
          @(negedge clk);
          out_ready = ((c % p) < q);
          #1;
          if (out_ready) begin
            check("R9 I word", {16'h0, oi0}, {16'h0, model[31:16]});
            check("R9 Q word", {16'h0, oq0}, {16'h0, model[15:0]});
            check("R11 ready when clear", in_ready0, 1);
            model++;
          end
        end
        exp_total += (24 / p) * q + (((24 % p) < q) ? (24 % p) : q);
        @(negedge clk); out_ready = 0;
        check("R8 count per transfer", cnt0, exp_total);
        check("R12 counts equal", cnt1, cnt0);
      end
    end

    // R3 R5 R6 R12: master sync over the shared line
    out_ready = 1;
    wr0(3'b011);
    for (int m = 1; m <= 5; m++) begin
      if (m > 1) @(negedge clk);
      check("R3 pulse on bit15", out0_io, (m == 1) ? 32'h8000 : 32'h0);
      check("R5 master dp_reset", dp0, (m == 4));
      check("R6 slave dp_reset", dp1, (m == 4));
      check("R12 aligned reset", dp1, dp0);
      if (m == 4) begin
        check("R11 in_ready blocked", in_ready0, 0);
        check("R11 out_valid blocked", out_valid0, 0);
      end
      if (m == 5) begin
        check("R5 master count cleared", cnt0, 0);
        check("R5 slave count cleared", cnt1, 0);
        check("R9 first sample zero", {oi0, oq0}, 0);
      end
    end
    out_ready = 0;

    // R3: back-to-back sync writes give a single pulse
    @(negedge clk); cfg0_wr = 1; cfg0_wdata = 3'b011;
    @(negedge clk);
    check("R3 first pulse", out0_io, 16'h8000);
    @(negedge clk); cfg0_wr = 0;
    check("R3 second write dropped", out0_io, 16'h0000);
    @(negedge clk);
    check("R3 still quiet", out0_io, 16'h0000);
    repeat (4) @(negedge clk);

    // R3: sync bit from a slave write gives no pulse
    wr1(3'b101);
    check("R3 slave sync no pulse", out1_io, 16'h0000);
    check("R4 slave still no oe", oe1_io, 16'h0000);

    // R6: direct pin drive into slave; u0 idle must ignore
    wr0(3'b000);
    check("R2 idle role no oe", oe0_io, 16'h0000);
    repeat (3) @(negedge clk);
    tb_pin = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R6 slave latency", dp1, (i == 3));
      check("R6 idle ignores pin", dp0, 0);
    end
    tb_pin = 0;
    wr1(3'b000);
    repeat (3) @(negedge clk);
    tb_pin = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check("R6 idle slave ignores pin", dp1, 0);
    end
    tb_pin = 0;

    // R10 passthrough
    count_mode = 0; out_ready = 1;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      in_i = 16'(v * 4097); in_q = ~in_i;
      #1;
      check("R10 I passthrough", {16'h0, oi0}, {16'h0, 16'(v * 4097)});
      check("R10 Q passthrough", {16'h0, oq0}, {16'h0, ~16'(v * 4097)});
    end

    // R7 clear by disable, then R9 carry across halves
    @(negedge clk); rx_enable = 0; count_mode = 1;
    #1;
    check("R7 disable blocks valid", out_valid0, 0);
    @(negedge clk);
    check("R7 count cleared by disable", cnt0, 0);
    rx_enable = 1;
    repeat (65540) @(negedge clk);
    check("R9 carry into I", {16'h0, oi0}, 32'h1);
    check("R9 low half after carry", {16'h0, oq0}, 32'h4);
    check("R8 long count", cnt0, 32'd65540);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule